// File: doc/BRIEF.md
# I2C Tuner Control Slave

This block is the serial control front end of a frequency synthesizer. It sits on an I2C bus as a slave, with SDA driven open-drain. It answers to a 7-bit address whose top five bits are fixed and whose two low bits come from a hardware selector, so four synthesizers can share one bus. The bus pins are oversampled by the system clock through flop synchronizers, and START and STOP are found as SDA edges while SCL is high.

In a write frame, the leading bit of each data byte gives its kind. A byte with MSB 0 opens a divider pair, and the byte after it completes the 15-bit divider. A byte with MSB 1 is the control byte, and the byte after it is the band byte. Each value is committed at its own acknowledge. The divider commits only when the pair is complete. Byte groups may follow one address in any order until STOP, so a host can sweep frequency without readdressing. In a read frame the slave returns one status byte that carries a power-on flag and the synthesizer's lock indication. The committed fields are exported to the rest of the synthesizer.

Top module: `tuner_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address bits 1,1,0,0,0,hw_addr[1],hw_addr[0] followed by R/W (R/W 0 = write, 1 = read). After a mismatching address it leaves SDA released and ignores every byte until the next START.
- R2: The slave pulls SDA low (sda_oe = 1) during the ninth clock after a matching address and after every write data byte, and at no other time in a write frame.
- R3: A data byte with bit 7 = 0 is the high divider byte: its bits 6..0 become div_n[14:8]. The next byte supplies div_n[7:0].
- R4: A data byte with bit 7 = 1 is the control byte: bit 6 -> cp_hi, bits 5..3 -> test_mode[2:0], bit 2 -> ref_sel[1], bit 1 -> ref_sel[0], bit 0 -> tune_off. It is committed at its acknowledge. The byte after it is the band byte, whose bits 2..0 drive band[2:0], committed at its own acknowledge.
- R5: div_n changes only at the acknowledge of the second divider byte. After the first byte alone, the previous value remains.
- R6: Any number of byte groups may follow a single address within one frame, and each one commits.
- R7: A divider pair cut short by STOP or a repeated START is discarded, and groups committed earlier in the frame stay in effect.
- R8: A read frame returns the status byte {por_flag, lock, 1,1,1,1,1,1}, MSB first, with lock taken from lock_i.
- R9: The power-on flag is 1 after reset and is cleared once a status byte has been fully shifted out.
- R10: After reset, div_n = 0, cp_hi = 0, test_mode = 0, ref_sel = 2'b11, tune_off = 1, band = 0 and sda_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| hw_addr | input | 2 | Hardware-selected low address bits |
| lock_i | input | 1 | Lock indication from the phase comparator |
| sda_oe | output | 1 | 1 = pull SDA low |
| div_n | output | 15 | Committed divider value |
| cp_hi | output | 1 | Charge pump high-current select |
| test_mode | output | 3 | Test mode select bits |
| ref_sel | output | 2 | Reference divider select |
| tune_off | output | 1 | Tuning amplifier disable |
| band | output | 3 | Band output port controls |

## Verification
The bench builds the block with its default parameters: a 15-bit divider and two synchronizer stages. The 15-bit divider lets a pair of bytes reach every divider value, including all-ones and a sweep that crosses the high byte. The two-stage synchronizer fixes the latency that the bus model's quarter-bit spacing must cover, so ACK timing and readback bit timing are checked as a real master would see them. Both address selector settings that the bench drives are tried against matching and non-matching address bytes.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam logic [4:0] ADDR_FIXED = 5'b11000;
  localparam int CTRL_W = 7;
  localparam logic [CTRL_W-1:0] CTRL_RST = 7'b0000111;
  localparam int BAND_W = 3;

  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_AACK, LK_WDAT, LK_WACK, LK_RDAT, LK_RACK
  } lk_state_e;

  typedef enum logic [1:0] {
    PD_NONE, PD_DIV2, PD_BAND
  } pend_e;
endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES+1];
  assign chain[0] = d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= RST_VAL;
      else        chain[g+1] <= chain[g];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/tcs_link.sv
module tcs_link
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [1:0] hw_addr,
  input  logic [7:0] status_byte,
  output logic       sda_oe,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       frame_rst,
  output logic       rd_done
);
  lk_state_e st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic       oe_q, oe_n;
  logic       scl_q, sda_q;
  logic       start, stop, rise, fall;

  assign start = scl_s & scl_q & sda_q & ~sda_s;
  assign stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise  = scl_s & ~scl_q;
  assign fall  = ~scl_s & scl_q;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; oe_n = oe_q;
    byte_stb = 1'b0; rd_done = 1'b0;
    if (start) begin
      st_n = LK_ADDR; cnt_n = '0; oe_n = 1'b0;
    end else if (stop) begin
      st_n = LK_IDLE; oe_n = 1'b0;
    end else begin
      case (st_q)
        LK_ADDR, LK_WDAT: begin
          if (rise) begin
            sh_n = {sh_q[6:0], sda_s}; cnt_n = cnt_q + 4'd1;
          end else if (fall && cnt_q == 4'd8) begin
            if (st_q == LK_WDAT) begin
              st_n = LK_WACK; oe_n = 1'b1;
            end else if (sh_q[7:1] == {ADDR_FIXED, hw_addr}) begin
              st_n = LK_AACK; oe_n = 1'b1;
            end else begin
              st_n = LK_IDLE;
            end
          end
        end
        LK_AACK: if (fall) begin
          cnt_n = '0;
          if (sh_q[0]) begin
            st_n = LK_RDAT; oe_n = ~status_byte[7]; sh_n = {status_byte[6:0], 1'b1};
          end else begin
            st_n = LK_WDAT; oe_n = 1'b0;
          end
        end
        LK_WACK: if (fall) begin
          st_n = LK_WDAT; oe_n = 1'b0; cnt_n = '0; byte_stb = 1'b1;
        end
        LK_RDAT: begin
          if (rise) cnt_n = cnt_q + 4'd1;
          else if (fall) begin
            if (cnt_q == 4'd8) begin
              st_n = LK_RACK; oe_n = 1'b0; rd_done = 1'b1;
            end else begin
              oe_n = ~sh_q[7]; sh_n = {sh_q[6:0], 1'b1};
            end
          end
        end
        LK_RACK: begin
          if (rise) sh_n = {sh_q[6:0], sda_s};
          else if (fall) begin
            cnt_n = '0;
            if (!sh_q[0]) begin
              st_n = LK_RDAT; oe_n = ~status_byte[7]; sh_n = {status_byte[6:0], 1'b1};
            end else begin
              st_n = LK_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LK_IDLE; cnt_q <= '0; sh_q <= '0; oe_q <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; oe_q <= oe_n;
      scl_q <= scl_s; sda_q <= sda_s;
    end
  end

  assign sda_oe    = oe_q;
  assign byte_data = sh_q;
  assign frame_rst = start | stop;

  // R2
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_ADDR || st_q == LK_WDAT) |-> !sda_oe);

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st_q == LK_IDLE && !sda_oe));
endmodule

// File: rtl/tcs_regs.sv
module tcs_regs
  import tcs_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              frame_rst,
  input  logic              rd_done,
  output logic [DIV_W-1:0]  div_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [BAND_W-1:0] band_q,
  output logic              por_q
);
  localparam int HI_W = DIV_W - 8;

  pend_e             pend_q, pend_n;
  logic [HI_W-1:0]   hold_q, hold_n;
  logic [DIV_W-1:0]  div_n;
  logic [CTRL_W-1:0] ctrl_n;
  logic [BAND_W-1:0] band_n;
  logic              por_n;

  always_comb begin
    pend_n = pend_q; hold_n = hold_q; div_n = div_q;
    ctrl_n = ctrl_q; band_n = band_q; por_n = por_q;
    if (rd_done) por_n = 1'b0;
    if (frame_rst) begin
      pend_n = PD_NONE;
    end else if (byte_stb) begin
      case (pend_q)
        PD_DIV2: begin div_n = {hold_q, byte_data}; pend_n = PD_NONE; end
        PD_BAND: begin band_n = byte_data[BAND_W-1:0]; pend_n = PD_NONE; end
        default: begin
          if (!byte_data[7]) begin
            hold_n = byte_data[HI_W-1:0]; pend_n = PD_DIV2;
          end else begin
            ctrl_n = byte_data[CTRL_W-1:0]; pend_n = PD_BAND;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PD_NONE; hold_q <= '0; div_q <= '0;
      ctrl_q <= CTRL_RST; band_q <= '0; por_q <= 1'b1;
    end else begin
      pend_q <= pend_n; hold_q <= hold_n; div_q <= div_n;
      ctrl_q <= ctrl_n; band_q <= band_n; por_q <= por_n;
    end
  end

  // R5
  div_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_stb && pend_q == PD_DIV2) |=> $stable(div_q));

  // R4
  band_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_stb && pend_q == PD_BAND) |=> $stable(band_q));

  // R9
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !por_q);
endmodule

// File: rtl/tuner_cfg_slave.sv
module tuner_cfg_slave
  import tcs_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       hw_addr,
  input  logic             lock_i,
  output logic             sda_oe,
  output logic [DIV_W-1:0] div_n,
  output logic             cp_hi,
  output logic [2:0]       test_mode,
  output logic [1:0]       ref_sel,
  output logic             tune_off,
  output logic [2:0]       band
);
  logic [2:0] pins_s;
  logic       byte_stb, frame_rst, rd_done, por;
  logic [7:0] byte_data, status_byte;
  logic [CTRL_W-1:0] ctrl;

  tcs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i, lock_i}), .q(pins_s));

  assign status_byte = {por, pins_s[0], 6'b111111};

  tcs_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(pins_s[2]), .sda_s(pins_s[1]),
    .hw_addr(hw_addr), .status_byte(status_byte), .sda_oe(sda_oe),
    .byte_stb(byte_stb), .byte_data(byte_data), .frame_rst(frame_rst),
    .rd_done(rd_done));

  tcs_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_data(byte_data),
    .frame_rst(frame_rst), .rd_done(rd_done), .div_q(div_n),
    .ctrl_q(ctrl), .band_q(band), .por_q(por));

  assign cp_hi     = ctrl[6];
  assign test_mode = ctrl[5:3];
  assign ref_sel   = ctrl[2:1];
  assign tune_off  = ctrl[0];
endmodule

// File: tb/tuner_cfg_slave_tb.sv
module tuner_cfg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] hw_addr = 2'b10;
  logic lock_i = 1'b1;
  logic sda_oe;
  logic [14:0] div_n;
  logic cp_hi, tune_off;
  logic [2:0] test_mode, band;
  logic [1:0] ref_sel;
  logic sda_line;
  logic last_ack;
  logic [7:0] last_rd;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  item_t q[$];
  event chk_ev, done_ev;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  tuner_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .hw_addr(hw_addr), .lock_i(lock_i), .sda_oe(sda_oe), .div_n(div_n),
    .cp_hi(cp_hi), .test_mode(test_mode), .ref_sel(ref_sel),
    .tune_off(tune_off), .band(band));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expect_val(input string req, input int sel, input logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
    -> chk_ev;
    @(done_ev);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(chk_ev);
      tick(2);
      while (q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = {17'd0, div_n};
          1: act = {25'd0, cp_hi, test_mode, ref_sel, tune_off};
          2: act = {29'd0, band};
          3: act = {31'd0, last_ack};
          4: act = {24'd0, last_rd};
          default: act = {31'd0, sda_oe};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
        end
      end
      -> done_ev;
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    seen = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    last_ack = s;
  endtask

  task automatic rd_byte(input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      last_rd[i] = s;
    end
    bus_bit(mack, s);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R10 reset state
    expect_val("R10 div reset", 0, 32'h0);
    expect_val("R10 ctrl reset", 1, 32'h07);
    expect_val("R10 band reset", 2, 32'h0);
    expect_val("R10 sda released", 5, 32'h0);

    // R8 R9 first read: por=1, lock=1
    bus_start(); wr_byte(8'hC5);
    expect_val("R1 read addr ack", 3, 32'h0);
    rd_byte(1'b1); bus_stop();
    expect_val("R8 status with por", 4, 32'hFF);
    bus_start(); wr_byte(8'hC5); rd_byte(1'b1); bus_stop();
    expect_val("R9 por cleared", 4, 32'h7F);

    // R3 R5 divider pair
    bus_start(); wr_byte(8'hC4);
    expect_val("R2 addr ack", 3, 32'h0);
    wr_byte(8'h12);
    expect_val("R2 data ack", 3, 32'h0);
    expect_val("R5 div held after first byte", 0, 32'h0);
    wr_byte(8'h34);
    expect_val("R3 div committed", 0, 32'h1234);
    bus_stop();

    // R4 R6 several groups in one frame
    bus_start(); wr_byte(8'hC4);
    wr_byte(8'hC9);
    expect_val("R4 ctrl fields", 1, 32'h49);
    expect_val("R4 band not yet", 2, 32'h0);
    wr_byte(8'h05);
    expect_val("R4 band fields", 2, 32'h5);
    wr_byte(8'h00); wr_byte(8'h10);
    expect_val("R6 sweep step 1", 0, 32'h0010);
    wr_byte(8'h7F); wr_byte(8'hFF);
    expect_val("R6 sweep step 2", 0, 32'h7FFF);
    bus_stop();

    // R1 wrong address
    bus_start(); wr_byte(8'hC0);
    expect_val("R1 mismatch nack", 3, 32'h1);
    wr_byte(8'h01); wr_byte(8'h02);
    expect_val("R1 ignored bytes not acked", 3, 32'h1);
    bus_stop();
    expect_val("R1 div untouched", 0, 32'h7FFF);

    // R7 abort by STOP
    bus_start(); wr_byte(8'hC4);
    wr_byte(8'hA0); wr_byte(8'h02); wr_byte(8'h15);
    bus_stop();
    expect_val("R7 div kept after abort", 0, 32'h7FFF);
    expect_val("R7 ctrl kept", 1, 32'h20);
    expect_val("R7 band kept", 2, 32'h2);

    // R7 abort by repeated START
    bus_start(); wr_byte(8'hC4); wr_byte(8'h05);
    bus_start(); wr_byte(8'hC4); wr_byte(8'h66);
    expect_val("R7 orphan discarded", 0, 32'h7FFF);
    wr_byte(8'h01);
    expect_val("R7 new pair after restart", 0, 32'h6601);
    bus_stop();

    // R1 other hardware address
    hw_addr = 2'b01;
    tick(5);
    bus_start(); wr_byte(8'hC4);
    expect_val("R1 old address nack", 3, 32'h1);
    bus_stop();
    bus_start(); wr_byte(8'hC2);
    expect_val("R1 new address ack", 3, 32'h0);
    wr_byte(8'h01); wr_byte(8'h23);
    expect_val("R3 div via new address", 0, 32'h0123);
    bus_stop();

    // R8 unlocked status
    lock_i = 1'b0;
    tick(5);
    bus_start(); wr_byte(8'hC3); rd_byte(1'b1); bus_stop();
    expect_val("R8 status unlocked", 4, 32'h3F);
    expect_val("R2 released after read", 5, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule